// File: doc/BRIEF.md
# Double-Buffered Calendar Register Window

This block sits between a byte-wide memory bus and an external calendar counter core. It claims the eight highest byte addresses of the bus address space and shows them as a small register file: one control byte and seven time bytes (seconds, minutes, hours, weekday, day of month, month, year). Each time byte has clock bits and, in some bytes, spare bits. The clock bits are holding copies of the live counters. The spare bits are plain storage. Any access outside the eight-byte window is passed unchanged to a separate RAM port.

The host can freeze the holding copies in two ways. A read-halt bit keeps a stable snapshot for reading while the counters keep running. A write-halt bit lets software load new time values. When the write-halt bit is cleared, the block gives the counter core a one-cycle load strobe together with the loaded values. Two more bits are stored here: an oscillator-stop bit, which is brought out to the core, and a frequency-test bit. When frequency test is on, the seconds LSB reads back a 512 Hz square wave. A power-fail input blocks every access.

Top module: `rtc_shadow_window`

## Requirements
- R1: The window is the eight addresses whose upper address bits are all ones. Address bits [2:0] select the byte: 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year. A window read returns the stored byte combinationally.
- R2: While control bits 7 and 6 are both 0, the clock bits of every time byte take the live counter value at each clock edge. The clock-bit masks are: seconds 0x7F, minutes 0x7F, hours 0x3F, weekday 0x07, day of month 0x3F, month 0x1F, year 0xFF.
- R3: Writing control with bit 6 (read halt) set freezes the clock bits at the live value sampled on that write edge. Later live changes stay hidden while the bit is set.
- R4: Writing the control byte with bits 7 and 6 cleared resumes updating of all time bytes together. The new live values are visible one cycle after the write edge.
- R5: While control bit 7 (write halt) is 1, host writes to the time bytes are kept. A control write with bit 7 cleared, while bit 7 was set, raises `load_pulse` for exactly one cycle, starting on the edge after the write. During that cycle `set_time` carries the masked holding bytes, with seconds in bits [7:0] and year in bits [55:48].
- R6: Seconds bit 7 is the oscillator-stop bit. `osc_halt` equals the stored value of this bit from the edge that writes it.
- R7: Weekday bit 6 is the frequency-test bit. When it is 1 and the oscillator-stop bit is 0, bit 0 of a seconds read returns `sq512`. Otherwise it returns the stored seconds LSB.
- R8: Bits outside the clock masks keep the value the host last wrote. The live counters never overwrite them.
- R9: While `pwr_fail` is 1, no write takes effect in the window or at the RAM port. `ram_sel` and `ram_we` stay 0 and `bus_rdata` reads 0.
- R10: An access outside the window asserts `ram_sel` and returns `ram_rdata`. It leaves every window byte unchanged.
- R11: After reset all window bytes are 0, and `load_pulse` and `osc_halt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select, active high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pwr_fail | input | 1 | Supply out of tolerance, blocks access |
| live_time | input | 56 | Live counter bytes, seconds in [7:0] to year in [55:48] |
| sq512 | input | 1 | 512 Hz square wave for frequency test |
| set_time | output | 56 | Masked holding bytes for the counter load |
| load_pulse | output | 1 | One-cycle counter load strobe |
| osc_halt | output | 1 | Oscillator-stop request |
| ram_sel | output | 1 | RAM port select |
| ram_we | output | 1 | RAM port write enable |
| ram_addr | output | AW | RAM port address |
| ram_wdata | output | 8 | RAM port write data |
| ram_rdata | input | 8 | RAM port read data |

## Verification
The hardest state to reach is a commit whose load values differ from the live counters. The commit strobe's data must then be told apart from the snapshot. The stimulus sets the write-halt bit and moves the live counters away from the host's values. It then loads different time bytes and clears the bit, and samples `set_time` inside the one strobe cycle. A second hard case is a spare bit next to clock bits that keep changing. This is reached by writing a mixed byte while unfrozen. The check then confirms that the spare half survives the overwrite from the live side.

// File: rtl/rtc_shadow_window.sv
module rtc_shadow_window #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          pwr_fail,
  input  logic [55:0]   live_time,
  input  logic          sq512,
  output logic [55:0]   set_time,
  output logic          load_pulse,
  output logic          osc_halt,
  output logic          ram_sel,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata
);
  localparam int NREG = 8;
  localparam int IW   = $clog2(NREG);

  function automatic logic [7:0] tmask(input int i);
    case (i)
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  logic [7:0] regs [NREG];
  logic       load_q;

  wire          acc    = bus_sel & ~pwr_fail;
  wire          in_win = &bus_addr[AW-1:IW];
  wire [IW-1:0] idx    = bus_addr[IW-1:0];
  wire          wr_win = acc & bus_we & in_win;
  wire          frozen = |regs[0][7:6];
  wire          commit = wr_win && (idx == '0) && !bus_wdata[7] && regs[0][7];
  wire          ft_on  = regs[4][6] & ~regs[1][7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= commit;
      for (int i = 1; i < NREG; i++)
        if (!frozen)
          regs[i] <= (regs[i] & ~tmask(i)) | (live_time[8*(i-1) +: 8] & tmask(i));
      if (wr_win) regs[idx] <= bus_wdata;
    end
  end

  for (genvar g = 1; g < NREG; g++) begin : g_set
    assign set_time[8*(g-1) +: 8] = regs[g] & tmask(g);
  end

  logic [7:0] win_val;
  always_comb begin
    win_val = regs[idx];
    if (idx == IW'(1) && ft_on) win_val[0] = sq512;
  end

  assign bus_rdata  = (acc && !bus_we) ? (in_win ? win_val : ram_rdata) : 8'h00;
  assign load_pulse = load_q;
  assign osc_halt   = regs[1][7];
  assign ram_sel    = acc & ~in_win;
  assign ram_we     = ram_sel & bus_we;
  assign ram_addr   = bus_addr;
  assign ram_wdata  = bus_wdata;
endmodule

module rtc_shadow_window_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic          pwr_fail,
  input logic [55:0]   set_time,
  input logic          load_pulse,
  input logic          osc_halt,
  input logic          ram_sel,
  input logic          ram_we,
  input logic [1:0]    frz
);
  localparam logic [AW-1:0] SEC_ADDR = {{(AW-3){1'b1}}, 3'd1};
  wire top8 = &bus_addr[AW-1:3];
  wire wr_ok = bus_sel && bus_we && !pwr_fail;

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> !load_pulse);

  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |-> ($past(frz[1]) && !frz[1]));

  assert_pfail_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |-> (!ram_sel && !ram_we && bus_rdata == 8'h00));

  assert_window_isolated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && top8) |-> !ram_sel);

  assert_freeze_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frz != 2'b00) && !$past(wr_ok)) |-> $stable(set_time));

  assert_osc_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ok && bus_addr == SEC_ADDR) |-> (osc_halt == $past(bus_wdata[7])));
endmodule

bind rtc_shadow_window rtc_shadow_window_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pwr_fail(pwr_fail), .set_time(set_time), .load_pulse(load_pulse),
  .osc_halt(osc_halt), .ram_sel(ram_sel), .ram_we(ram_we),
  .frz(regs[0][7:6])
);

// File: tb/test_rtc_shadow_window.sv
module test_rtc_shadow_window;
  localparam int AW = 17;
  localparam logic [AW-1:0] BASE = {{(AW-3){1'b1}}, 3'd0};

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_we = 0, pwr_fail = 0, sq512 = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, ram_rdata = '0;
  logic [7:0] live [7];
  logic [55:0] live_time;
  logic [7:0] bus_rdata, ram_wdata;
  logic [55:0] set_time;
  logic load_pulse, osc_halt, ram_sel, ram_we;
  logic [AW-1:0] ram_addr;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < 7; i++) live_time[8*i +: 8] = live[i];

  rtc_shadow_window #(.AW(AW)) i_rtc_shadow_window (
    .clk, .rst_n, .bus_sel, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
    .pwr_fail, .live_time, .sq512, .set_time, .load_pulse, .osc_halt,
    .ram_sel, .ram_we, .ram_addr, .ram_wdata, .ram_rdata);

  typedef struct {
    int         kind;
    int         idx;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic expect_now(int kind, int idx, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [7:0] exp, string req);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    expect_now(0, 0, exp, req);
    @(negedge clk);
    bus_sel = 0;
  endtask

  always begin
    @(negedge clk);
    #4;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = bus_rdata;
        1: act = {7'd0, load_pulse};
        2: act = {7'd0, ram_sel};
        3: act = {7'd0, osc_halt};
        default: act = set_time[8*it.idx +: 8];
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    live[0] = 8'h12; live[1] = 8'h34; live[2] = 8'h05; live[3] = 8'h02;
    live[4] = 8'h15; live[5] = 8'h06; live[6] = 8'h24;
    idle(2);
    expect_now(1, 0, 8'h00, "R11 load_pulse");
    expect_now(3, 0, 8'h00, "R11 osc_halt");
    rd(BASE + 0, 8'h00, "R11 control reset");
    rst_n = 1;
    idle(1);

    // R2 tracking
    live[0] = 8'h45; live[1] = 8'h30; live[2] = 8'h17; live[6] = 8'h99;
    idle(1);
    rd(BASE + 1, 8'h45, "R2 seconds follow");
    rd(BASE + 7, 8'h99, "R2 year follow");
    rd(BASE + 5, 8'h15, "R1 date byte");

    // R8 spare bits
    wr(BASE + 2, 8'hA3);
    wr(BASE + 3, 8'hC0);
    idle(1);
    rd(BASE + 2, 8'hB0, "R8 minutes spare kept");
    rd(BASE + 3, 8'hD7, "R8 hours spare kept");

    // R3 read halt
    wr(BASE + 0, 8'h40);
    live[0] = 8'h46;
    idle(2);
    rd(BASE + 1, 8'h45, "R3 snapshot held");
    rd(BASE + 0, 8'h40, "R1 control readback");

    // R4 resume
    wr(BASE + 0, 8'h00);
    idle(1);
    rd(BASE + 1, 8'h46, "R4 resume seconds");
    rd(BASE + 7, 8'h99, "R4 resume year");

    // R5 write halt and commit
    wr(BASE + 0, 8'h80);
    wr(BASE + 1, 8'h30);
    wr(BASE + 2, 8'h15);
    wr(BASE + 3, 8'h09);
    live[0] = 8'h50;
    idle(1);
    rd(BASE + 1, 8'h30, "R5 loaded seconds kept");
    expect_now(1, 0, 8'h00, "R5 no pulse while halted");
    wr(BASE + 0, 8'h00);
    expect_now(1, 0, 8'h01, "R5 pulse");
    expect_now(4, 0, 8'h30, "R5 set seconds");
    expect_now(4, 1, 8'h15, "R5 set minutes");
    expect_now(4, 2, 8'h09, "R5 set hours");
    live[0] = 8'h30; live[1] = 8'h15; live[2] = 8'h09;
    idle(1);
    expect_now(1, 0, 8'h00, "R5 pulse one cycle");
    idle(1);
    rd(BASE + 3, 8'h09, "R5 hours after commit");

    // R6 oscillator stop, R7 frequency test
    wr(BASE + 1, 8'h80);
    expect_now(3, 0, 8'h01, "R6 osc_halt set");
    idle(1);
    rd(BASE + 1, 8'hB0, "R6 seconds with stop bit");
    wr(BASE + 4, 8'h40);
    idle(1);
    rd(BASE + 4, 8'h42, "R7 weekday with test bit");
    sq512 = 1;
    rd(BASE + 1, 8'hB0, "R7 no square while stopped");
    wr(BASE + 1, 8'h00);
    expect_now(3, 0, 8'h00, "R6 osc_halt cleared");
    idle(1);
    rd(BASE + 1, 8'h31, "R7 square high");
    sq512 = 0;
    rd(BASE + 1, 8'h30, "R7 square low");

    // R9 power fail
    wr(BASE + 3, 8'hC0);
    idle(1);
    rd(BASE + 3, 8'hC9, "R8 hours spare set");
    pwr_fail = 1;
    wr(BASE + 3, 8'h00);
    wr(BASE + 0, 8'h40);
    bus_sel = 1; bus_we = 1; bus_addr = 17'h00100;
    expect_now(2, 0, 8'h00, "R9 ram_sel blocked");
    idle(1);
    bus_sel = 0; bus_we = 0;
    rd(BASE + 7, 8'h00, "R9 read blocked");
    pwr_fail = 0;
    idle(1);
    rd(BASE + 3, 8'hC9, "R9 hours untouched");
    rd(BASE + 0, 8'h00, "R9 control untouched");

    // R10 outside window
    bus_sel = 1; bus_we = 1; bus_addr = 17'h00100; bus_wdata = 8'h5A;
    expect_now(2, 0, 8'h01, "R10 ram_sel on write");
    idle(1);
    bus_sel = 0; bus_we = 0;
    ram_rdata = 8'hC3;
    rd(17'h00100, 8'hC3, "R10 ram read data");
    wr(17'h0FFF8, 8'hFF);
    idle(1);
    rd(BASE + 0, 8'h00, "R10 window unchanged");
    rd(BASE + 2, 8'h15, "R10 minutes unchanged");

    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule